// File: doc/BRIEF.md
# Command-Started Serial Character Transmitter

This block turns bytes held in a small transmit queue into an asynchronous serial bit stream on a single line. Software, or an upstream engine, writes characters into the queue first. Nothing leaves the block until a start strobe arrives. From then on, every queued character goes out back to back. Each character is wrapped in a low start bit, a programmable number of data bits sent least significant first, an optional parity bit, and one or two high stop bits.

While the queue drains, the block raises a refill request whenever the queue is half empty or emptier. When the final stop bit of the last queued character has gone out, it gives a one-cycle completion pulse. After that pulse the line stays at the idle mark level (logic 1) until the next start strobe.

The bit period is set by dividing the block clock by a programmable factor. No separate oversampling or mode selection affects the transmit side.

Top module: `async_char_tx`

## Requirements
- R1: Writing characters into the queue never starts transmission by itself; with no start strobe, `txd` stays at 1.
- R2: Data bits are sent least significant bit first.
- R3: A character begins with one start bit at 0, followed by the data bits. `cfg_len` sets the data length: 0, 1, 2 and 3 select 5, 6, 7 and 8 bits.
- R4: `cfg_par` sets the parity bit that follows the data. A value of 0 or 3 adds no parity bit. A value of 1 adds even parity, so the data bits plus the parity bit hold an even count of ones. A value of 2 adds odd parity.
- R5: `cfg_two_stop` set to 0 ends each character with one stop bit at 1; set to 1 it ends with two.
- R6: Every bit on `txd` lasts `cfg_div`+1 clock cycles. The start bit appears in the cycle after the start strobe is sampled, and queued characters follow each other with no gap.
- R7: `pool_ready` is 1 exactly when the queue holds DEPTH/2 (8) characters or fewer.
- R8: `all_sent` pulses for exactly one cycle, in the cycle after the last stop bit of the last queued character. `txd` is 1 in that cycle and stays 1 until the next start strobe.
- R9: A start strobe while the queue is empty is ignored: `txd` stays 1 and `all_sent` does not pulse.
- R10: `fifo_full` is 1 when the queue holds DEPTH (16) characters, and a write made while it is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Character to queue |
| start_cmd | input | 1 | Transmit start strobe |
| cfg_div | input | 16 | Bit period minus one, in clock cycles |
| cfg_len | input | 2 | Data length select (5 to 8 bits) |
| cfg_par | input | 2 | Parity select: 0/3 none, 1 even, 2 odd |
| cfg_two_stop | input | 1 | Two stop bits when set |
| txd | output | 1 | Serial output line |
| pool_ready | output | 1 | Refill request, queue at half or below |
| all_sent | output | 1 | One-cycle completion pulse |
| fifo_full | output | 1 | Queue full |

## Verification
`pool_ready` and `fifo_full` follow a write in the next cycle. The start bit appears one cycle after the start strobe is sampled. Each later bit boundary falls a further `cfg_div`+1 cycles on, and `all_sent` is due exactly one bit period after the last stop bit begins. The bench drives inputs on the falling edge. It walks a cycle-accurate expected waveform and compares `txd` on every falling edge of every bit, so a bit that is early, late or too long is caught in the exact cycle it goes wrong. Refill status is compared at the first cycle of each character, when the queue has just lost one entry.

// File: rtl/tx_pkg.sv
// Package tx_pkg
// Shared constants and the frame builder for the serial transmitter.
// Assumes characters of at most CHAR_W bits and at most two stop bits.
package tx_pkg;
    localparam int CHAR_W    = 8;
    localparam int MIN_LEN   = 5;
    localparam int FRAME_MAX = 1 + CHAR_W + 1 + 2;
    localparam int NB_W      = $clog2(FRAME_MAX + 1);

    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;

    typedef struct packed {
        logic [NB_W-1:0]      nbits;
        logic [FRAME_MAX-1:0] bits;
    } frame_t;

    // Assemble start, data (LSB first), optional parity and stop bits.
    function automatic frame_t build_frame(
        input logic [CHAR_W-1:0] data,
        input logic [1:0]        len_sel,
        input logic [1:0]        par_sel,
        input logic              two_stop
    );
        frame_t f;
        int n_data;
        int idx;
        logic [CHAR_W-1:0] masked;
        logic par_bit;
        n_data = int'(len_sel) + MIN_LEN;
        masked = '0;
        f.bits = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < n_data) begin
                masked[i]      = data[i];
                f.bits[1 + i]  = data[i];
            end
        end
        idx = 1 + n_data;
        if (par_sel == PAR_EVEN || par_sel == PAR_ODD) begin
            par_bit = ^masked;
            if (par_sel == PAR_ODD) par_bit = ~par_bit;
            f.bits[idx] = par_bit;
            idx = idx + 1;
        end
        idx = idx + (two_stop ? 2 : 1);
        f.nbits = NB_W'(idx);
        return f;
    endfunction
endpackage

// File: rtl/tx_fifo.sv
// Module tx_fifo
// Synchronous single-clock queue for transmit characters.
// Assumes DEPTH is a power of two; writes while full are dropped,
// reads are only issued when not empty.
module tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_wr;
    logic             do_rd;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign count   = count_q;
    assign rd_data = mem_q[rd_ptr_q];
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;

    // Store accepted characters.
    always_ff @(posedge clk) begin
        if (do_wr) mem_q[wr_ptr_q] <= wr_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_wr) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_rd) rd_ptr_q <= rd_ptr_q + 1'b1;
            if (do_wr && !do_rd)      count_q <= count_q + 1'b1;
            else if (do_rd && !do_wr) count_q <= count_q - 1'b1;
        end
    end

    // R10: a write into a full queue with no read leaves occupancy unchanged.
    a_r10_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> $stable(count_q));

    // R9: the framer never pops an empty queue.
    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/tx_baud.sv
// Module tx_baud
// Bit-period divider: while run is high, tick pulses once every div+1 cycles,
// the first tick div+1 cycles after run rises. Assumes div is stable while run.
module tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= div);

    // Count cycles within the current bit, restarting on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    // R6: the counter is cleared whenever the divider is idle.
    a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/tx_framer.sv
// Module tx_framer
// Loads one character per frame from the queue, shifts it out on each bit
// tick, chains characters back to back, and pulses all_sent when the queue
// runs dry. Assumes configuration is stable while busy.
module tx_framer
    import tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [CHAR_W-1:0] q_data,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_two_stop,
    output logic              pop,
    output logic              busy,
    output logic              txd,
    output logic              all_sent
);
    logic                 busy_q;
    logic [FRAME_MAX-1:0] shreg_q;
    logic [NB_W-1:0]      left_q;
    logic                 all_sent_q;
    logic                 char_end;
    logic                 load;
    frame_t               next_frame;

    // Detect the end of the last bit of the current character.
    assign char_end = busy_q && tick && (left_q == NB_W'(1));

    // Load on an accepted start command or to chain the next character.
    assign load = (!busy_q && start_cmd && !q_empty) || (char_end && !q_empty);

    // Build the frame for the character at the head of the queue.
    always_comb begin
        next_frame = build_frame(q_data, cfg_len, cfg_par, cfg_two_stop);
    end

    assign pop      = load;
    assign busy     = busy_q;
    assign txd      = shreg_q[0];
    assign all_sent = all_sent_q;

    // Shift register, bit counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            shreg_q    <= '1;
            left_q     <= '0;
            all_sent_q <= 1'b0;
        end else begin
            all_sent_q <= char_end && q_empty;
            if (load) begin
                busy_q  <= 1'b1;
                shreg_q <= next_frame.bits;
                left_q  <= next_frame.nbits;
            end else if (char_end) begin
                busy_q  <= 1'b0;
                shreg_q <= '1;
                left_q  <= '0;
            end else if (busy_q && tick) begin
                shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
                left_q  <= left_q - 1'b1;
            end
        end
    end

    // R1: sending only begins after a start command.
    a_r1_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start_cmd));

    // R3: the first bit of a transmission is the low start bit.
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> !txd);

    // R6: the line holds its bit between ticks.
    a_r6_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !$past(tick)) |-> $stable(txd));

    // R8: completion is a single-cycle pulse with the line at mark.
    a_r8_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
        all_sent_q |=> !all_sent_q);
    a_r8_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        all_sent_q |-> (txd && !busy_q));
endmodule

// File: rtl/async_char_tx.sv
// Module async_char_tx
// Command-started asynchronous character transmitter: queue, bit-rate
// divider and framer. Assumes configuration changes only while idle.
module async_char_tx
    import tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              start_cmd,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_two_stop,
    output logic              txd,
    output logic              pool_ready,
    output logic              all_sent,
    output logic              fifo_full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int HALF  = DEPTH / 2;

    logic              q_pop;
    logic              q_empty;
    logic [CHAR_W-1:0] q_data;
    logic [CNT_W-1:0]  q_count;
    logic              busy;
    logic              bit_tick;

    tx_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (q_pop),
        .rd_data (q_data),
        .empty   (q_empty),
        .full    (fifo_full),
        .count   (q_count)
    );

    tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (cfg_div),
        .tick  (bit_tick)
    );

    tx_framer u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_cmd    (start_cmd),
        .tick         (bit_tick),
        .q_empty      (q_empty),
        .q_data       (q_data),
        .cfg_len      (cfg_len),
        .cfg_par      (cfg_par),
        .cfg_two_stop (cfg_two_stop),
        .pop          (q_pop),
        .busy         (busy),
        .txd          (txd),
        .all_sent     (all_sent)
    );

    // Refill request from queue occupancy.
    assign pool_ready = (q_count <= CNT_W'(HALF));

    // R7: a full queue never asks for more data.
    a_r7_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !pool_ready);
endmodule

// File: tb/test_async_char_tx.sv
module test_async_char_tx;
    localparam int DEPTH = 16;
    localparam int HALF  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        start_cmd = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [1:0]  cfg_len = '0;
    logic [1:0]  cfg_par = '0;
    logic        cfg_two_stop = 1'b0;
    logic        txd;
    logic        pool_ready;
    logic        all_sent;
    logic        fifo_full;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [DEPTH];
    int occ = 0;

    always #2.5 clk = ~clk;

    async_char_tx i_async_char_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .start_cmd(start_cmd), .cfg_div(cfg_div), .cfg_len(cfg_len),
        .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .txd(txd),
        .pool_ready(pool_ready), .all_sent(all_sent), .fifo_full(fifo_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bit count of a frame per R3, R4, R5.
    function automatic int frame_bits(input logic [1:0] len, input logic [1:0] par,
                                      input logic two);
        int n;
        n = 2 + int'(len) + 5;
        if (par == 2'd1 || par == 2'd2) n++;
        if (two) n++;
        return n;
    endfunction

    // Expected level of bit k of a frame per R2, R3, R4, R5.
    function automatic logic frame_bit(input logic [7:0] d, input logic [1:0] len,
                                       input logic [1:0] par, input int k);
        int nd;
        int ones;
        nd = int'(len) + 5;
        if (k == 0) return 1'b0;
        if (k <= nd) return d[k-1];
        if ((par == 2'd1 || par == 2'd2) && k == nd + 1) begin
            ones = 0;
            for (int i = 0; i < nd; i++) ones += int'(d[i]);
            return (par == 2'd1) ? logic'(ones % 2) : logic'(1 - ones % 2);
        end
        return 1'b1;
    endfunction

    // Queue one character; R7 and R10 checked the cycle after the write.
    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (occ < DEPTH) begin
            exp_q[occ] = d;
            occ++;
        end
        chk(pool_ready == (occ <= HALF), "R7", "pool_ready after write",
            int'(pool_ready), int'(occ <= HALF));
        chk(fifo_full == (occ == DEPTH), "R10", "fifo_full after write",
            int'(fifo_full), int'(occ == DEPTH));
    endtask

    // Start and follow the whole burst cycle by cycle (R2-R8).
    task automatic run_burst(input int div, input logic [1:0] len,
                             input logic [1:0] par, input logic two);
        int total;
        int nb;
        logic e;
        total = occ;
        nb = frame_bits(len, par, two);
        cfg_div = 16'(div);
        cfg_len = len;
        cfg_par = par;
        cfg_two_stop = two;
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        for (int ch = 0; ch < total; ch++) begin
            chk(pool_ready == ((total - ch - 1) <= HALF), "R7", "pool_ready while sending",
                int'(pool_ready), int'((total - ch - 1) <= HALF));
            for (int k = 0; k < nb; k++) begin
                e = frame_bit(exp_q[ch], len, par, k);
                for (int c = 0; c <= div; c++) begin
                    chk(txd == e, (k == 0) ? "R3" : "R6", "txd bit level",
                        int'(txd), int'(e));
                    chk(all_sent == 1'b0, "R8", "no early all_sent", int'(all_sent), 0);
                    @(negedge clk);
                end
            end
        end
        chk(all_sent == 1'b1, "R8", "all_sent after last stop", int'(all_sent), 1);
        chk(txd == 1'b1, "R8", "txd mark at completion", int'(txd), 1);
        occ = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(all_sent == 1'b0 && txd == 1'b1, "R8", "idle after completion",
                int'({all_sent, txd}), 1);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R8", "reset txd", int'(txd), 1);
        chk(pool_ready == 1'b1, "R7", "reset pool_ready", int'(pool_ready), 1);
        chk(all_sent == 1'b0, "R8", "reset all_sent", int'(all_sent), 0);
        chk(fifo_full == 1'b0, "R10", "reset fifo_full", int'(fifo_full), 0);

        // R9: start on an empty queue is ignored.
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        for (int i = 0; i < 30; i++) begin
            chk(txd == 1'b1 && all_sent == 1'b0, "R9", "empty start ignored",
                int'({txd, all_sent}), 2);
            @(negedge clk);
        end

        // R1: queued data waits for the start command.
        write_byte(8'hA5);
        write_byte(8'h3C);
        for (int i = 0; i < 40; i++) begin
            chk(txd == 1'b1, "R1", "no send without start", int'(txd), 1);
            @(negedge clk);
        end
        run_burst(3, 2'd3, 2'd0, 1'b0);

        // R2/R4: 8-bit odd parity, two stop bits, one-cycle bits.
        write_byte(8'h01);
        write_byte(8'h80);
        write_byte(8'hFF);
        run_burst(0, 2'd3, 2'd2, 1'b1);

        // R3/R4: 5-bit even parity, upper bits must not appear.
        write_byte(8'hF3);
        write_byte(8'hE0);
        run_burst(2, 2'd0, 2'd1, 1'b0);

        // R10: overflow, 17th write dropped; 16 chars then all_sent.
        for (int i = 0; i < DEPTH + 1; i++) write_byte(8'(i * 7 + 1));
        run_burst(1, 2'd2, 2'd3, 1'b1);

        // Randomized bursts covering R2-R8.
        for (int b = 0; b < 12; b++) begin
            int n;
            n = $urandom_range(1, DEPTH + 2);
            for (int i = 0; i < n; i++) write_byte(8'($urandom));
            run_burst($urandom_range(0, 4), 2'($urandom), 2'($urandom), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule